// File: doc/BRIEF.md
# Boundary-Scan Self-Test Pattern Engine

This block advances the built-in self-test operation of the 36 data boundary cells of a two-byte bidirectional transceiver. Cells 0 to 17 are the input-side cells and take their values from the input pins. Cells 18 to 35 are the output-side cells and feed the pins through shadow latches. A 3-bit opcode selects one of five algorithms:
- sample the inputs while the outputs toggle
- 36-bit pseudo-random pattern generation
- 36-bit parallel signature compression
- 18-bit signature compression running alongside 18-bit pattern generation
- 18-bit signature compression running alongside an 18-bit up-counter

The engine takes one step on each rising test-clock edge while the run-test instruction is active and the test controller is in Run-Test/Idle. It also requires a legal data-flow direction. Each byte must drive in one direction only, and both bytes must drive the same way. When the direction check fails, the block falls back to bypass and no cell moves. New output-side values reach the shadow latches on the next falling edge.

The cells start from a seed that is a parameter, because loading them through the serial scan path is out of scope. The per-byte drive enables come from control cells that no algorithm touches. They pass through to the pin drivers unchanged.

Top module: `bsst_engine`

## Requirements
- R1: While reset is asserted, `cells_q` equals the parameter `RESET_SEED` (default 36'h1) and `shadow_q` is zero.
- R2: The cells change only on a rising `tck` edge where `run_instr` and `in_idle` are both 1 and the direction check passes; on every other edge all 36 cells keep their value.
- R3: The direction check passes only when, for each byte b, `oe_a[b]` and `oe_b[b]` are not both 1, and `oe_a[0]==oe_a[1]` and `oe_b[0]==oe_b[1]`; a failing check leaves every cell unchanged.
- R4: `drive_en` equals `oe_cell` at all times, in every mode, and is never altered by any algorithm.
- R5: With opcode bits [1:0]=00 (opcode x00), a step loads `in_pins` into cells 17..0 and inverts cells 35..18.
- R6: With opcode x01, a step shifts all 36 cells up by one (cell i takes cell i-1), and cell 0 takes cell35 XOR cell24 (polynomial x^36+x^25+1).
- R7: With opcode x10, a step performs the 36-bit shift of R6 and then XORs `in_pins` into cells 17..0.
- R8: With opcode 011, cells 17..0 form an 18-bit signature register (cell 0 takes cell17 XOR cell10 XOR pin 0, and cell i takes cell i-1 XOR pin i), and cells 35..18 form an 18-bit generator (x^18+x^11+1) with cell 18 taking cell35 XOR cell28.
- R9: With opcode 111, cells 17..0 compress as in R8, and cells 35..18 hold an unsigned count (LSB at cell 18) that rises by one per step and wraps from all ones to zero.
- R10: On the falling `tck` edge after a step, `shadow_q` takes cells 35..18. After a rising edge with no step, `shadow_q` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; cells step on rising edge, shadow latches load on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_instr | input | 1 | Run-test instruction is active |
| in_idle | input | 1 | Test controller is in Run-Test/Idle |
| opcode | input | 3 | Self-test opcode |
| oe_a | input | 2 | Per-byte A-side output enable, bit b for byte b |
| oe_b | input | 2 | Per-byte B-side output enable, bit b for byte b |
| oe_cell | input | 2 | Output-enable control cell values, one per output group |
| in_pins | input | 18 | Pin values observed by the input-side cells |
| cells_q | output | 36 | Shift elements of the data cells (17..0 input side, 35..18 output side) |
| shadow_q | output | 18 | Shadow latches driving the output pins |
| drive_en | output | 2 | Per-group pin drive enable (1 = drive, 0 = high impedance) |

## Verification
The assertions assume that `tck` runs freely and that `rst_n` is released away from both clock edges. They also assume that the opcode, the enables and `in_pins` settle between a falling edge and the next rising edge, so the shadow and step properties can read them as stable at the rising edge. The bench changes every input just after a falling edge. It releases reset at that same point, so each step depends only on values that were set up before the rising edge. Both legal direction settings are covered, as are mixed and double-enabled illegal settings, so the fallback to bypass is exercised as well as the stepping.

// File: rtl/bsst_pkg.sv
package bsst_pkg;

   typedef enum logic [2:0] {
      MODE_TOGGLE,
      MODE_GEN_WIDE,
      MODE_SIG_WIDE,
      MODE_SIG_GEN_HALF,
      MODE_SIG_CNT_HALF
   } bsst_mode_e;

   function automatic bsst_mode_e bsst_decode(input logic [2:0] op);
      case (op[1:0])
         2'b00:   return MODE_TOGGLE;
         2'b01:   return MODE_GEN_WIDE;
         2'b10:   return MODE_SIG_WIDE;
         default: return op[2] ? MODE_SIG_CNT_HALF : MODE_SIG_GEN_HALF;
      endcase
   endfunction

endpackage

// File: rtl/bsst_dir_check.sv
module bsst_dir_check #(
   parameter int NBYTE = 2
) (
   input  logic [NBYTE-1:0] oe_a,
   input  logic [NBYTE-1:0] oe_b,
   output logic             legal
);
   logic [NBYTE-1:0] byte_ok;

   generate
      if (NBYTE < 1) begin : g_bad
         $error("bsst_dir_check: NBYTE must be at least 1");
      end
      for (genvar b = 0; b < NBYTE; b++) begin : g_byte
         // one direction per byte, and same direction as byte 0
         assign byte_ok[b] = !(oe_a[b] && oe_b[b])
                             && (oe_a[b] == oe_a[0])
                             && (oe_b[b] == oe_b[0]);
      end
   endgenerate

   assign legal = &byte_ok;
endmodule

// File: rtl/bsst_next.sv
module bsst_next
   import bsst_pkg::*;
#(
   parameter int HALF_W = 18,
   parameter int TAP_W  = 25,
   parameter int TAP_H  = 11
) (
   input  bsst_mode_e              mode,
   input  logic [2*HALF_W-1:0]     cur,
   input  logic [HALF_W-1:0]       pins,
   output logic [2*HALF_W-1:0]     nxt
);
   localparam int W = 2 * HALF_W;

   logic [HALF_W-1:0] in_h, out_h;
   logic [W-1:0]      gen_wide;
   logic [HALF_W-1:0] sig_half, gen_half, cnt_half;

   assign in_h  = cur[HALF_W-1:0];
   assign out_h = cur[W-1:HALF_W];

   generate
      if (TAP_W < 1 || TAP_W >= W) begin : g_bad_w
         $error("bsst_next: TAP_W out of range");
      end
      if (TAP_H < 1 || TAP_H >= HALF_W) begin : g_bad_h
         $error("bsst_next: TAP_H out of range");
      end
   endgenerate

   always_comb begin
      gen_wide = {cur[W-2:0], cur[W-1] ^ cur[TAP_W-1]};
      sig_half = {in_h[HALF_W-2:0], in_h[HALF_W-1] ^ in_h[TAP_H-1]} ^ pins;
      gen_half = {out_h[HALF_W-2:0], out_h[HALF_W-1] ^ out_h[TAP_H-1]};
      cnt_half = out_h + 1'b1;
   end

   always_comb begin
      unique case (mode)
         MODE_TOGGLE:       nxt = {~out_h, pins};
         MODE_GEN_WIDE:     nxt = gen_wide;
         MODE_SIG_WIDE:     nxt = gen_wide ^ {{HALF_W{1'b0}}, pins};
         MODE_SIG_GEN_HALF: nxt = {gen_half, sig_half};
         MODE_SIG_CNT_HALF: nxt = {cnt_half, sig_half};
         default:           nxt = cur;
      endcase
   end
endmodule

// File: rtl/bsst_engine.sv
module bsst_engine
   import bsst_pkg::*;
#(
   parameter int                  HALF_W     = 18,
   parameter int                  NBYTE      = 2,
   parameter int                  TAP_W      = 25,
   parameter int                  TAP_H      = 11,
   parameter logic [2*HALF_W-1:0] RESET_SEED = 36'h1
) (
   input  logic                tck,
   input  logic                rst_n,
   input  logic                run_instr,
   input  logic                in_idle,
   input  logic [2:0]          opcode,
   input  logic [NBYTE-1:0]    oe_a,
   input  logic [NBYTE-1:0]    oe_b,
   input  logic [NBYTE-1:0]    oe_cell,
   input  logic [HALF_W-1:0]   in_pins,
   output logic [2*HALF_W-1:0] cells_q,
   output logic [HALF_W-1:0]   shadow_q,
   output logic [NBYTE-1:0]    drive_en
);
   localparam int W = 2 * HALF_W;

   generate
      if (HALF_W < 2) begin : g_bad_half
         $error("bsst_engine: HALF_W must be at least 2");
      end
   endgenerate

   logic       legal, advance, adv_q;
   bsst_mode_e mode;
   logic [W-1:0] nxt;

   assign mode    = bsst_decode(opcode);
   assign advance = run_instr && in_idle && legal;
   assign drive_en = oe_cell;

   bsst_dir_check #(.NBYTE(NBYTE)) u_dir (
      .oe_a  (oe_a),
      .oe_b  (oe_b),
      .legal (legal)
   );

   bsst_next #(.HALF_W(HALF_W), .TAP_W(TAP_W), .TAP_H(TAP_H)) u_next (
      .mode (mode),
      .cur  (cells_q),
      .pins (in_pins),
      .nxt  (nxt)
   );

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         cells_q <= RESET_SEED;
         adv_q   <= 1'b0;
      end else begin
         adv_q <= advance;
         if (advance) cells_q <= nxt;
      end
   end

   always_ff @(negedge tck or negedge rst_n) begin
      if (!rst_n)     shadow_q <= '0;
      else if (adv_q) shadow_q <= cells_q[W-1:HALF_W];
   end

   // R2 / R3: no step, no change
   a_r2_hold: assert property (@(posedge tck) disable iff (!rst_n)
      !(run_instr && in_idle) |=> $stable(cells_q));
   a_r3_bypass: assert property (@(posedge tck) disable iff (!rst_n)
      !legal |=> $stable(cells_q));
   // R5: toggle mode
   a_r5_toggle: assert property (@(posedge tck) disable iff (!rst_n)
      (advance && opcode[1:0] == 2'b00) |=>
         (cells_q[W-1:HALF_W] == ~$past(cells_q[W-1:HALF_W]))
         && (cells_q[HALF_W-1:0] == $past(in_pins)));
   // R9: counter
   a_r9_count: assert property (@(posedge tck) disable iff (!rst_n)
      (advance && opcode == 3'b111) |=>
         cells_q[W-1:HALF_W] == $past(cells_q[W-1:HALF_W]) + 1'b1);
   // R10: shadow follows after a step, holds otherwise
   a_r10_shadow_load: assert property (@(posedge tck) disable iff (!rst_n)
      adv_q |-> shadow_q == cells_q[W-1:HALF_W]);
   a_r10_shadow_hold: assert property (@(posedge tck) disable iff (!rst_n)
      !adv_q |-> $stable(shadow_q));
endmodule

// File: tb/tb_bsst_engine.sv
module tb_bsst_engine;
   logic        tck = 1'b0;
   logic        rst_n = 1'b0;
   logic        run_instr = 1'b0, in_idle = 1'b0;
   logic [2:0]  opcode = '0;
   logic [1:0]  oe_a = '0, oe_b = '0, oe_cell = '0;
   logic [17:0] in_pins = '0;
   logic [35:0] cells_q, cells2_q;
   logic [17:0] shadow_q, shadow2_q;
   logic [1:0]  drive_en, drive2_en;

   int n_chk = 0, n_bad = 0;

   always #5 tck = ~tck;

   bsst_engine dut (
      .tck(tck), .rst_n(rst_n), .run_instr(run_instr), .in_idle(in_idle),
      .opcode(opcode), .oe_a(oe_a), .oe_b(oe_b), .oe_cell(oe_cell),
      .in_pins(in_pins), .cells_q(cells_q), .shadow_q(shadow_q),
      .drive_en(drive_en));

   bsst_engine #(.RESET_SEED({18'h3FFFE, 18'h00001})) dut_wrap (
      .tck(tck), .rst_n(rst_n), .run_instr(run_instr), .in_idle(in_idle),
      .opcode(opcode), .oe_a(oe_a), .oe_b(oe_b), .oe_cell(oe_cell),
      .in_pins(in_pins), .cells_q(cells2_q), .shadow_q(shadow2_q),
      .drive_en(drive2_en));

   typedef struct packed {
      logic [2:0]  op;
      logic [1:0]  oa;
      logic [1:0]  ob;
      logic        lg;
      logic [17:0] sd;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VT [NV] = '{
      '{3'b000, 2'b11, 2'b00, 1'b1, 18'h15A3C},
      '{3'b100, 2'b00, 2'b11, 1'b1, 18'h0F0F1},
      '{3'b001, 2'b11, 2'b00, 1'b1, 18'h00000},
      '{3'b101, 2'b00, 2'b11, 1'b1, 18'h3C3C3},
      '{3'b010, 2'b11, 2'b00, 1'b1, 18'h2A5A5},
      '{3'b110, 2'b00, 2'b11, 1'b1, 18'h11111},
      '{3'b011, 2'b11, 2'b00, 1'b1, 18'h3FFFF},
      '{3'b111, 2'b00, 2'b11, 1'b1, 18'h1E1E1},
      '{3'b000, 2'b01, 2'b00, 1'b0, 18'h12345},
      '{3'b111, 2'b11, 2'b01, 1'b0, 18'h2BCDE},
      '{3'b001, 2'b00, 2'b10, 1'b0, 18'h0AAAA},
      '{3'b010, 2'b11, 2'b11, 1'b0, 18'h35555}
   };

   function automatic string req_of(input logic [2:0] op, input logic lg);
      if (!lg) return "R3";
      case (op[1:0])
         2'b00:   return "R5";
         2'b01:   return "R6";
         2'b10:   return "R7";
         default: return op[2] ? "R9" : "R8";
      endcase
   endfunction

   function automatic logic [35:0] mdl_next(input logic [2:0] op,
                                            input logic [35:0] c,
                                            input logic [17:0] p);
      logic [35:0] r;
      logic [17:0] lo, hi;
      r = c;
      for (int i = 1; i < 36; i++) r[i] = c[i-1];
      r[0] = c[35] ^ c[24];
      for (int i = 1; i < 18; i++) begin
         lo[i] = c[i-1] ^ p[i];
         hi[i] = c[18+i-1];
      end
      lo[0] = c[17] ^ c[10] ^ p[0];
      hi[0] = c[35] ^ c[28];
      case (op[1:0])
         2'b00:   return {~c[35:18], p};
         2'b01:   return r;
         2'b10:   return {r[35:18], r[17:0] ^ p};
         default: return op[2] ? {c[35:18] + 18'd1, lo} : {hi, lo};
      endcase
   endfunction

   task automatic check(input string req, input string what,
                        input logic [35:0] got, input logic [35:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge tck); #1 rst_n = 1'b0;
      @(negedge tck); #1 rst_n = 1'b1;
   endtask

   task automatic run_vec(input vec_t v, input int ncyc);
      logic [35:0] mc;
      logic [17:0] ms;
      logic        step;
      run_instr = 1'b0;
      do_reset();
      opcode = v.op; oe_a = v.oa; oe_b = v.ob; oe_cell = v.op[1:0];
      run_instr = 1'b1; in_idle = 1'b1;
      mc = 36'h1; ms = '0;
      for (int k = 0; k < ncyc; k++) begin
         in_pins = v.sd ^ 18'(k * 18'h2F3D1);
         step = v.lg;
         @(posedge tck);
         if (step) mc = mdl_next(v.op, mc, in_pins);
         #1 check(req_of(v.op, v.lg), "cells", cells_q, mc);
         @(negedge tck);
         if (step) ms = mc[35:18];
         #1 check("R10", "shadow", {18'h0, shadow_q}, {18'h0, ms});
      end
      check("R4", "drive_en", {34'h0, drive_en}, {34'h0, v.op[1:0]});
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [35:0] held;
      // R1: reset state
      #12;
      check("R1", "reset cells", cells_q, 36'h1);
      check("R1", "reset shadow", {18'h0, shadow_q}, 36'h0);
      @(negedge tck); #1 rst_n = 1'b1;

      // table walk: each opcode legal, plus illegal directions (R3)
      for (int i = 0; i < NV; i++) run_vec(VT[i], VT[i].lg ? 100 : 20);

      // R2: legal toggle but controller not in idle, then instruction off
      do_reset();
      opcode = 3'b000; oe_a = 2'b11; oe_b = 2'b00; in_pins = 18'h2AAAA;
      run_instr = 1'b1; in_idle = 1'b0;
      repeat (4) @(negedge tck);
      #1 check("R2", "not idle", cells_q, 36'h1);
      check("R10", "shadow hold", {18'h0, shadow_q}, 36'h0);
      run_instr = 1'b0; in_idle = 1'b1;
      repeat (4) @(negedge tck);
      #1 check("R2", "no instruction", cells_q, 36'h1);
      // one step then freeze
      run_instr = 1'b1;
      @(negedge tck); #1 held = cells_q;
      check("R5", "single toggle", held, {18'h3FFFF, 18'h2AAAA});
      check("R10", "shadow after step", {18'h0, shadow_q}, 36'h3FFFF);
      run_instr = 1'b0; in_pins = 18'h0;
      repeat (3) @(negedge tck);
      #1 check("R2", "frozen", cells_q, held);

      // R9: counter wrap on second instance (output half seeded 3FFFE)
      do_reset();
      opcode = 3'b111; oe_a = 2'b00; oe_b = 2'b11; in_pins = '0;
      run_instr = 1'b1; in_idle = 1'b1;
      @(negedge tck); #1 check("R9", "count to all ones", {18'h0, cells2_q[35:18]}, 36'h3FFFF);
      @(negedge tck); #1 check("R9", "wrap to zero", {18'h0, cells2_q[35:18]}, 36'h0);
      check("R10", "shadow wrap", {18'h0, shadow2_q}, 36'h0);

      // R4: drive enables untouched by an illegal setting too
      oe_cell = 2'b10; oe_a = 2'b01;
      #1 check("R4", "drive pass", {34'h0, drive_en}, {34'h0, 2'b10});

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule